// File: doc/BRIEF.md
# Tagged Branch Target Predictor

A small direct-mapped predictor that a fetch stage queries every cycle. It has four lines. Each line holds a valid flag, an address tag, a branch target and a two-flag history. The first history flag is the next-direction guess. The second records whether the last guess was right. Because of this pairing, a single wrong guess only marks the history as doubtful. The predicted direction flips only after two wrong guesses in a row.

The lookup side is purely combinational from the fetch PC. It returns a hit flag, a taken guess and a next PC. The update side is registered. It takes a resolved branch PC, its real direction and its real target. On a tag match it refines the history. On a mismatch it takes over the whole line and seeds the history from the real direction. A test-only preload port can write any line with any tag, target and history.

Top module: `btb_predictor`

## Requirements
- R1: After reset no line is valid, so every lookup reports hit=0 until the line has been written.
- R2: The line index is PC[3:2] and the tag is PC[31:4]. A branch at 0x6C uses line 3 with tag 0x0000006, and a PC with the same index but another tag misses.
- R3: On a lookup hit, the taken output equals the stored next-direction flag (1 = taken) and the target output is the stored target.
- R4: On a lookup miss, hit=0, taken=0 and the target output is the lookup PC plus 4.
- R5: An update that hits and whose direction equals the stored guess keeps the guess and sets the last-correct flag to 1.
- R6: An update that hits, disagrees with the guess and finds the last-correct flag at 1 keeps the guess and clears the flag to 0.
- R7: An update that hits, disagrees with the guess and finds the last-correct flag at 0 sets the guess to the real direction and the flag to 1.
- R8: An update that misses writes the line's tag and target and sets the history to guess=direction, last-correct=1. An update that hits leaves tag and target unchanged.
- R9: With the update-valid input low, the update inputs change nothing.
- R10: A lookup made in the same cycle as an update to the same line returns the contents from before that update.
- R11: A preload writes the chosen line's tag, target and both history flags and marks the line valid. When a preload and an update arrive in the same cycle, the preload wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Tag matched a valid line |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | 32 | Stored target on a hit, PC+4 on a miss |
| up_valid | input | 1 | Apply a resolved branch this cycle |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Real direction of the resolved branch |
| up_target | input | 32 | Real target of the resolved branch |
| pl_en | input | 1 | Test preload strobe |
| pl_index | input | 2 | Line to preload |
| pl_tag | input | 28 | Tag to preload |
| pl_target | input | 32 | Target to preload |
| pl_next | input | 1 | Next-direction flag to preload |
| pl_last | input | 1 | Last-correct flag to preload |

## Verification
The bench builds the block with its default 32-bit addresses and two index bits. At that size all four lines can be swept. Each of the four history states can be preloaded in every line and followed by both directions, which covers all eight history transitions on every line. A pseudo-random trace drawn from a handful of tags then mixes hits, misses and replacements, and every line is probed after each step. The last-correct flag is seen through the guesses that follow.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef struct packed {
        logic n;   // next-direction guess, 1 = taken
        logic l;   // last guess was correct
    } hist_t;

    function automatic hist_t hist_next(hist_t cur, logic taken);
        hist_t nx;
        nx = cur;
        if (taken == cur.n) begin
            nx.l = 1'b1;
        end else if (cur.l) begin
            nx.l = 1'b0;
        end else begin
            nx.n = taken;
            nx.l = 1'b1;
        end
        return nx;
    endfunction

    function automatic hist_t hist_seed(logic taken);
        hist_t nx;
        nx.n = taken;
        nx.l = 1'b1;
        return nx;
    endfunction

endpackage

// File: rtl/btb_line.sv
module btb_line
    import btb_pkg::*;
#(
    parameter int TAG_W  = 28,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [TAG_W-1:0]  upd_tag,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              pl_en,
    input  logic [TAG_W-1:0]  pl_tag,
    input  logic [ADDR_W-1:0] pl_target,
    input  hist_t             pl_hist,
    output logic              valid_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [ADDR_W-1:0] target_o,
    output hist_t             hist_o
);

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] target;
        hist_t             hist;
    } line_t;

    line_t st_d, st_q;
    logic  upd_hit;

    assign upd_hit = st_q.valid && (st_q.tag == upd_tag);

    always_comb begin
        st_d = st_q;
        if (pl_en) begin
            st_d.valid  = 1'b1;
            st_d.tag    = pl_tag;
            st_d.target = pl_target;
            st_d.hist   = pl_hist;
        end else if (upd_en) begin
            if (upd_hit) begin
                st_d.hist = hist_next(st_q.hist, upd_taken);
            end else begin
                st_d.valid  = 1'b1;
                st_d.tag    = upd_tag;
                st_d.target = upd_target;
                st_d.hist   = hist_seed(upd_taken);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o  = st_q.valid;
    assign tag_o    = st_q.tag;
    assign target_o = st_q.target;
    assign hist_o   = st_q.hist;

    assert_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !pl_en && upd_hit && upd_taken == st_q.hist.n)
        |=> (st_q.hist.l && st_q.hist.n == $past(st_q.hist.n)));

    assert_first_wrong_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !pl_en && upd_hit && upd_taken != st_q.hist.n && st_q.hist.l)
        |=> (!st_q.hist.l && st_q.hist.n == $past(st_q.hist.n)));

    assert_second_wrong_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !pl_en && upd_hit && upd_taken != st_q.hist.n && !st_q.hist.l)
        |=> (st_q.hist.l && st_q.hist.n == $past(upd_taken)));

    assert_replace_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !pl_en && !upd_hit)
        |=> (st_q.valid && st_q.tag == $past(upd_tag) && st_q.target == $past(upd_target)
             && st_q.hist.n == $past(upd_taken) && st_q.hist.l));

    assert_hit_keeps_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !pl_en && upd_hit) |=> ($stable(st_q.target) && $stable(st_q.tag)));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !pl_en) |=> $stable(st_q));

    assert_preload_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pl_en |=> (st_q.valid && st_q.tag == $past(pl_tag) && st_q.hist == $past(pl_hist)));

endmodule

// File: rtl/btb_read.sv
module btb_read
    import btb_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 28,
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]             pc,
    input  logic [LINES-1:0]              valid,
    input  logic [LINES-1:0][TAG_W-1:0]   tags,
    input  logic [LINES-1:0][ADDR_W-1:0]  targets,
    input  hist_t [LINES-1:0]             hists,
    output logic                          hit,
    output logic                          taken,
    output logic [ADDR_W-1:0]             target
);

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;

    assign idx = pc[IDX_W+1:2];
    assign tag = pc[ADDR_W-1:IDX_W+2];

    always_comb begin
        hit    = valid[idx] && (tags[idx] == tag);
        taken  = hit && hists[idx].n;
        target = hit ? targets[idx] : pc + ADDR_W'(4);
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2,
    localparam int LINES = 1 << IDX_W,
    localparam int TAG_W = ADDR_W - IDX_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target,
    input  logic              pl_en,
    input  logic [IDX_W-1:0]  pl_index,
    input  logic [TAG_W-1:0]  pl_tag,
    input  logic [ADDR_W-1:0] pl_target,
    input  logic              pl_next,
    input  logic              pl_last
);

    logic [LINES-1:0]              valid;
    logic [LINES-1:0][TAG_W-1:0]   tags;
    logic [LINES-1:0][ADDR_W-1:0]  targets;
    hist_t [LINES-1:0]             hists;
    logic [IDX_W-1:0]              up_idx;
    hist_t                         pl_hist;

    assign up_idx    = up_pc[IDX_W+1:2];
    assign pl_hist.n = pl_next;
    assign pl_hist.l = pl_last;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        btb_line #(
            .TAG_W  (TAG_W),
            .ADDR_W (ADDR_W)
        ) i_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .upd_en     (up_valid && (up_idx == IDX_W'(g))),
            .upd_tag    (up_pc[ADDR_W-1:IDX_W+2]),
            .upd_taken  (up_taken),
            .upd_target (up_target),
            .pl_en      (pl_en && (pl_index == IDX_W'(g))),
            .pl_tag     (pl_tag),
            .pl_target  (pl_target),
            .pl_hist    (pl_hist),
            .valid_o    (valid[g]),
            .tag_o      (tags[g]),
            .target_o   (targets[g]),
            .hist_o     (hists[g])
        );
    end

    btb_read #(
        .LINES  (LINES),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .ADDR_W (ADDR_W)
    ) i_read (
        .pc      (lk_pc),
        .valid   (valid),
        .tags    (tags),
        .targets (targets),
        .hists   (hists),
        .hit     (lk_hit),
        .taken   (lk_taken),
        .target  (lk_target)
    );

    assert_miss_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_taken && lk_target == lk_pc + ADDR_W'(4)));

    assert_reset_empty_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (valid == '0));

    assert_hit_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_target == targets[lk_pc[IDX_W+1:2]]));

endmodule

// File: tb/test_btb_predictor.sv
module test_btb_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit, lk_taken;
    logic [31:0] lk_target;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [31:0] up_target = '0;
    logic        pl_en = 1'b0;
    logic [1:0]  pl_index = '0;
    logic [27:0] pl_tag = '0;
    logic [31:0] pl_target = '0;
    logic        pl_next = 1'b0, pl_last = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_valid [4];
    logic [27:0] m_tag   [4];
    logic [31:0] m_tgt   [4];
    logic        m_n     [4];
    logic        m_l     [4];

    always #4 clk = ~clk;

    btb_predictor i_btb_predictor (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target),
        .pl_en(pl_en), .pl_index(pl_index), .pl_tag(pl_tag), .pl_target(pl_target),
        .pl_next(pl_next), .pl_last(pl_last)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pc=%h actual=%h expected=%h", req, lk_pc, act, exp);
        end
    endtask

    // Lookup of a line through its modelled tag, plus a same-index alias that must miss
    task automatic probe_line(int i, string req);
        logic [1:0] ii = 2'(i);
        lk_pc = {m_tag[i], ii, 2'b00};
        #1;
        chk(req, 32'(lk_hit), 32'(m_valid[i]));
        chk(req, 32'(lk_taken), 32'(m_valid[i] && m_n[i]));
        chk(req, lk_target, m_valid[i] ? m_tgt[i] : lk_pc + 32'd4);
        lk_pc = {m_tag[i] ^ 28'h8000001, ii, 2'b00};
        #1;
        chk("R2 alias", 32'(lk_hit), 32'd0);
        chk("R4 miss target", lk_target, lk_pc + 32'd4);
    endtask

    task automatic probe_all(string req);
        for (int i = 0; i < 4; i++) probe_line(i, req);
    endtask

    // History rules written as the requirement table
    task automatic model_update(logic [31:0] pc, logic t, logic [31:0] tgt);
        int i = int'(pc[3:2]);
        if (m_valid[i] && m_tag[i] == pc[31:4]) begin
            if (t == m_n[i]) m_l[i] = 1'b1;          // R5
            else if (m_l[i]) m_l[i] = 1'b0;          // R6
            else begin m_n[i] = t; m_l[i] = 1'b1; end // R7
        end else begin                                // R8
            m_valid[i] = 1'b1; m_tag[i] = pc[31:4]; m_tgt[i] = tgt;
            m_n[i] = t; m_l[i] = 1'b1;
        end
    endtask

    task automatic do_update(logic [31:0] pc, logic t, logic [31:0] tgt);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_taken = t; up_target = tgt;
        model_update(pc, t, tgt);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic do_preload(int i, logic [27:0] tg, logic [31:0] tgt, logic n, logic l);
        @(negedge clk);
        pl_en = 1'b1; pl_index = 2'(i); pl_tag = tg; pl_target = tgt; pl_next = n; pl_last = l;
        m_valid[i] = 1'b1; m_tag[i] = tg; m_tgt[i] = tgt; m_n[i] = n; m_l[i] = l;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr = 32'h1234_5678;
        for (int i = 0; i < 4; i++) begin
            m_valid[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_n[i] = 0; m_l[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        probe_all("R1 reset empty");

        // R2: example mapping, 0x6C lands in line 3 with tag 6
        do_update(32'h0000_006C, 1'b1, 32'h0000_0100);
        lk_pc = 32'h0000_006C; #1;
        chk("R2 hit 0x6C", 32'(lk_hit), 32'd1);
        chk("R3 target 0x6C", lk_target, 32'h0000_0100);
        lk_pc = 32'h0000_007C; #1;
        chk("R2 other tag", 32'(lk_hit), 32'd0);
        probe_all("R8 seed");

        // R5/R6/R7: every history state and direction on every line, via preload (R11)
        for (int i = 0; i < 4; i++)
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < 2; o++) begin
                    do_preload(i, 28'(i * 16 + s + 3), 32'h1000 + 32'(i * 64 + s), s[1], s[0]);
                    probe_line(i, "R11 preload");
                    do_update({28'(i * 16 + s + 3), 2'(i), 2'b00}, o[0], 32'hDEAD_0000);
                    probe_line(i, "R5/R6/R7 history, R8 target kept");
                    // second identical outcome exposes the last-correct flag
                    do_update({28'(i * 16 + s + 3), 2'(i), 2'b00}, o[0], 32'hDEAD_0004);
                    probe_line(i, "R6/R7 second outcome");
                end

        // Mixed trace of hits, misses and replacements
        for (int k = 0; k < 300; k++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            do_update({28'(lfsr[5:4]), lfsr[3:2], 2'b00}, lfsr[9], {lfsr[31:12], 12'h0});
            probe_all("R5-trace R8-trace");
        end

        // R9: update inputs ignored while up_valid is low
        @(negedge clk);
        up_pc = {m_tag[1] ^ 28'h3, 2'd1, 2'b00}; up_taken = ~m_n[1]; up_target = 32'hBAD0_0000;
        @(negedge clk); @(negedge clk);
        probe_all("R9 no update");

        // R10: same-cycle lookup returns pre-update contents
        do_preload(2, 28'h5, 32'h2000, 1'b1, 1'b0);
        @(negedge clk);
        up_valid = 1'b1; up_pc = 32'h58; up_taken = 1'b0; up_target = 32'h0;
        lk_pc = 32'h58; #1;
        chk("R10 pre-update taken", 32'(lk_taken), 32'd1);
        chk("R10 pre-update target", lk_target, 32'h2000);
        model_update(32'h58, 1'b0, 32'h0);
        @(negedge clk);
        up_valid = 1'b0;
        lk_pc = 32'h58; #1;
        chk("R7 post-update taken", 32'(lk_taken), 32'd0);
        probe_line(2, "R10 after");

        // R11: preload wins over same-cycle update on that line
        @(negedge clk);
        pl_en = 1'b1; pl_index = 2'd1; pl_tag = 28'hABC; pl_target = 32'h7770; pl_next = 1'b1; pl_last = 1'b0;
        up_valid = 1'b1; up_pc = 32'h0000_1234; up_taken = 1'b0; up_target = 32'h1;
        m_valid[1] = 1; m_tag[1] = 28'hABC; m_tgt[1] = 32'h7770; m_n[1] = 1; m_l[1] = 0;
        @(negedge clk);
        pl_en = 1'b0; up_valid = 1'b0;
        probe_line(1, "R11 preload priority");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule